// File: doc/BRIEF.md
# GPIO Expander Interrupt Unit

This block watches a parameterised bank of general-purpose input lines and turns changes on them into interrupt requests. Each raw pin first passes through a two-flop synchroniser. A per-line detector then classifies the change according to a 2-bit event selection: a difference from a stored reference, a rising edge, a falling edge or either edge. Each line owns a small two-state machine, with the states LN_IDLE (nothing pending) and LN_PEND (event pending). The transition LN_IDLE to LN_PEND is taken on an event. The transition LN_PEND to LN_IDLE is taken on a clear-register write, on a port read when the line's latch is on, or on the pin returning to its reference value when the latch is off. A new event in the same cycle holds the line in LN_PEND.

The host reaches the block through a flat register port: address, write data, write strobe, read strobe and registered read data that is valid one cycle after the strobe. Reading the input port has side effects. It acknowledges the pending state of every latched line and reloads the per-line reference value used by level mode. A second address returns the same pin values with no side effect. A single active-low interrupt output is low while any pending line is also unmasked.

Top module: `gpio_irq_unit`

## Requirements
- R1: A pin change is first seen by the detector after two synchronising flops; with the line unmasked, `irq_n` goes low after the third rising clock edge that follows the change, and not after the second.
- R2: The mode code of line i is {bit i of the select-high register (address 7), bit i of the select-low register (address 6)}: 0 = the synchronised value differs from the line's reference, 1 = rising edge, 2 = falling edge, 3 = either edge. A status bit never sets without an event of the selected kind.
- R3: The mask register (address 2) has one bit per line, and 1 enables the line. `irq_n` is low exactly when some line is both pending and enabled. Status (address 3, 1 = pending) is recorded whether or not the line is masked.
- R4: After reset the mask, latch (address 5), both select registers and all status bits are 0, and `irq_n` is high.
- R5: A line whose latch bit is 1 stays pending until the input port is read (address 0). That read returns the synchronised pin values one cycle after the strobe and clears every latched pending line.
- R6: A line whose latch bit is 0 leaves the pending state without any read once its synchronised value is back at its reference. In edge modes the reference is the value held just before the edge. In level mode it is the value captured at the last input-port read.
- R7: Writing the clear register (address 4) clears the status of each line whose write-data bit is 1. A 0 bit leaves that line unchanged.
- R8: A read of the peek address (address 1) returns the synchronised pin values one cycle after the strobe and clears no status.
- R9: An event that is detected in the same cycle as a clear write or a port read for its line wins, and the line stays pending.
- R10: An input-port read loads every line's level-mode reference with the current synchronised value, so a level-mode line whose pin stays at that value raises no new event afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NLINES | Raw asynchronous input pins |
| addr | input | 3 | Register address |
| wdata | input | NLINES | Write data |
| wr_stb | input | 1 | Write strobe, one cycle |
| rd_stb | input | 1 | Read strobe, one cycle |
| rdata | output | NLINES | Read data, valid the cycle after rd_stb |
| irq_n | output | 1 | Active-low aggregated interrupt |

## Verification
Two actions can land on one line in the same cycle: a freshly detected edge and a host acknowledge, either a clear-register write or an input-port read. The bench provokes this case by changing a pin and then raising the clear-write strobe so that it is sampled at exactly the clock edge where the detector first sees the synchronised edge. The line is judged correct when a following status read still shows it pending. Level mode meets a similar overlap when a port read coincides with a reference mismatch, and this is judged by the line staying quiet after the read.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_PORT   = 3'd0,
        A_PEEK   = 3'd1,
        A_MASK   = 3'd2,
        A_STAT   = 3'd3,
        A_CLR    = 3'd4,
        A_LATCH  = 3'd5,
        A_SEL_LO = 3'd6,
        A_SEL_HI = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        EV_LEVEL = 2'd0,
        EV_RISE  = 2'd1,
        EV_FALL  = 2'd2,
        EV_ANY   = 2'd3
    } ev_mode_e;

    typedef enum logic {
        LN_IDLE = 1'b0,
        LN_PEND = 1'b1
    } line_state_e;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int NLINES = 16,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] raw,
    output logic [NLINES-1:0] smp
);
    logic [NLINES-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= raw;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign smp = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     smp,
    input  ev_mode_e mode,
    input  logic     latch_en,
    input  logic     port_rd,
    input  logic     clr,
    output logic     evt,
    output logic     pend
);
    logic        prev_q;
    logic        ref_q;
    line_state_e st_q, st_d;

    // event classification
    always_comb begin
        unique case (mode)
            EV_LEVEL: evt = (smp ^ ref_q) & ~port_rd;
            EV_RISE:  evt = smp & ~prev_q;
            EV_FALL:  evt = ~smp & prev_q;
            EV_ANY:   evt = smp ^ prev_q;
        endcase
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LN_IDLE: if (evt) st_d = LN_PEND;
            LN_PEND: begin
                if (evt)                    st_d = LN_PEND;
                else if (clr)               st_d = LN_IDLE;
                else if (latch_en&&port_rd) st_d = LN_IDLE;
                else if (!latch_en && (smp == ref_q)) st_d = LN_IDLE;
            end
        endcase
    end

    // state register and sample history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= LN_IDLE;
            prev_q <= 1'b0;
            ref_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            prev_q <= smp;
            if (mode == EV_LEVEL) begin
                if (port_rd) ref_q <= smp;
            end else if (evt) begin
                ref_q <= prev_q;
            end else if (st_q == LN_IDLE) begin
                ref_q <= smp;
            end
        end
    end

    // outputs
    always_comb begin
        pend = (st_q == LN_PEND);
    end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NLINES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NLINES-1:0] wdata,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [NLINES-1:0] smp,
    input  logic [NLINES-1:0] status,
    output logic [NLINES-1:0] rdata,
    output logic [NLINES-1:0] mask_q,
    output logic [NLINES-1:0] latch_q,
    output logic [NLINES-1:0] sel_lo_q,
    output logic [NLINES-1:0] sel_hi_q,
    output logic [NLINES-1:0] clr_vec,
    output logic              port_rd
);
    reg_addr_e         a;
    logic [NLINES-1:0] rd_mux;

    assign a       = reg_addr_e'(addr);
    assign port_rd = rd_stb && (a == A_PORT);
    assign clr_vec = (wr_stb && (a == A_CLR)) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '0;
            latch_q  <= '0;
            sel_lo_q <= '0;
            sel_hi_q <= '0;
        end else if (wr_stb) begin
            unique case (a)
                A_MASK:   mask_q   <= wdata;
                A_LATCH:  latch_q  <= wdata;
                A_SEL_LO: sel_lo_q <= wdata;
                A_SEL_HI: sel_hi_q <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (a)
            A_PORT, A_PEEK: rd_mux = smp;
            A_MASK:         rd_mux = mask_q;
            A_STAT:         rd_mux = status;
            A_LATCH:        rd_mux = latch_q;
            A_SEL_LO:       rd_mux = sel_lo_q;
            A_SEL_HI:       rd_mux = sel_hi_q;
            default:        rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_stb) rdata <= rd_mux;
    end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NLINES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] pin_in,
    input  logic [2:0]        addr,
    input  logic [NLINES-1:0] wdata,
    input  logic              wr_stb,
    input  logic              rd_stb,
    output logic [NLINES-1:0] rdata,
    output logic              irq_n
);
    logic [NLINES-1:0] smp;
    logic [NLINES-1:0] status_q;
    logic [NLINES-1:0] evt_vec;
    logic [NLINES-1:0] mask_q, latch_q, sel_lo_q, sel_hi_q, clr_vec;
    logic              port_rd;

    gpio_irq_sync #(.NLINES(NLINES), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(pin_in), .smp(smp)
    );

    gpio_irq_regs #(.NLINES(NLINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .smp(smp), .status(status_q),
        .rdata(rdata), .mask_q(mask_q), .latch_q(latch_q),
        .sel_lo_q(sel_lo_q), .sel_hi_q(sel_hi_q),
        .clr_vec(clr_vec), .port_rd(port_rd)
    );

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        gpio_irq_line u_line (
            .clk(clk), .rst_n(rst_n), .smp(smp[i]),
            .mode(ev_mode_e'({sel_hi_q[i], sel_lo_q[i]})),
            .latch_en(latch_q[i]), .port_rd(port_rd), .clr(clr_vec[i]),
            .evt(evt_vec[i]), .pend(status_q[i])
        );
    end

    assign irq_n = ~|(status_q & mask_q);
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
    parameter int NLINES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        addr,
    input logic              rd_stb,
    input logic [NLINES-1:0] rdata,
    input logic              irq_n,
    input logic [NLINES-1:0] smp,
    input logic [NLINES-1:0] status_q,
    input logic [NLINES-1:0] evt_vec,
    input logic [NLINES-1:0] mask_q,
    input logic [NLINES-1:0] latch_q,
    input logic [NLINES-1:0] clr_vec,
    input logic              port_rd
);
    // R4
    mask_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '0 && latch_q == '0 && status_q == '0));

    // R3
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> irq_n);

    // R2
    status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~$past(status_q) & ~$past(evt_vec)) == '0));

    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(port_rd) |->
            ((~status_q & $past(status_q & latch_q & ~clr_vec)) == '0));

    // R8
    peek_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_stb) && $past(addr) == 3'd1) |-> (rdata == $past(smp)));
endmodule

bind gpio_irq_unit gpio_irq_chk #(.NLINES(NLINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_stb(rd_stb),
    .rdata(rdata), .irq_n(irq_n), .smp(smp), .status_q(status_q),
    .evt_vec(evt_vec), .mask_q(mask_q), .latch_q(latch_q),
    .clr_vec(clr_vec), .port_rd(port_rd)
);

// File: tb/tb_gpio_irq_unit.sv
module tb_gpio_irq_unit;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_in = '0;
    logic [2:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic         wr_stb = 1'b0;
    logic         rd_stb = 1'b0;
    logic [N-1:0] rdata;
    logic         irq_n;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gpio_irq_unit #(.NLINES(N)) dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .addr(addr),
        .wdata(wdata), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .rdata(rdata), .irq_n(irq_n)
    );

    // vector: [6:5] mode, [4] latch, [3] start pin, [2] changed pin,
    //         [1] status after change, [0] status after return
    localparam logic [6:0] VEC [9] = '{
        7'b0000110, 7'b0001010, 7'b0010111,
        7'b0100110, 7'b0110111, 7'b0101001,
        7'b1001010, 7'b1010101, 7'b1100111
    };

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk); addr = a; wdata = d; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        @(negedge clk); addr = a; rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0; d = rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [N-1:0] v;
        settle(4);
        rst_n = 1'b1;
        settle(1);

        // R4 reset state
        check("R4 irq_n", {15'd0, irq_n}, 16'h0001);
        rd(3'd2, v); check("R4 mask", v, 16'h0000);
        rd(3'd5, v); check("R4 latch", v, 16'h0000);
        rd(3'd3, v); check("R4 status", v, 16'h0000);
        rd(3'd7, v); check("R4 sel_hi", v, 16'h0000);

        wr(3'd2, 16'h0001);
        for (int k = 0; k < 9; k++) begin
            logic [6:0] e;
            e = VEC[k];
            wr(3'd6, {15'd0, e[5]});
            wr(3'd7, {15'd0, e[6]});
            wr(3'd5, {15'd0, e[4]});
            @(negedge clk); pin_in[0] = e[3];
            settle(4);
            rd(3'd0, v);
            wr(3'd4, 16'hFFFF);
            settle(1);
            @(negedge clk); pin_in[0] = e[2];
            settle(4);
            // R2 R3 R6 table row
            rd(3'd3, v); check($sformatf("R2 row%0d change", k), v, {15'd0, e[1]});
            check($sformatf("R3 row%0d irq_n", k), {15'd0, irq_n}, {15'd0, ~e[1]});
            @(negedge clk); pin_in[0] = e[3];
            settle(4);
            rd(3'd3, v); check($sformatf("R6 row%0d return", k), v, {15'd0, e[0]});
        end

        // line 0: rise, latched
        wr(3'd6, 16'h0001); wr(3'd7, 16'h0000); wr(3'd5, 16'h0001);
        @(negedge clk); pin_in[0] = 1'b0;
        settle(4);
        rd(3'd0, v); wr(3'd4, 16'hFFFF); settle(1);

        // R1 latency
        @(negedge clk); pin_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 irq_n after two edges", {15'd0, irq_n}, 16'h0001);
        @(negedge clk);
        check("R1 irq_n after three edges", {15'd0, irq_n}, 16'h0000);

        // R8 peek keeps status
        rd(3'd1, v); check("R8 peek data", v, 16'h0001);
        rd(3'd3, v); check("R8 status kept", v, 16'h0001);

        // R7 clear with zero bit, then one bit
        wr(3'd4, 16'hFFFE);
        rd(3'd3, v); check("R7 zero bit no effect", v, 16'h0001);
        wr(3'd4, 16'h0001);
        rd(3'd3, v); check("R7 clear", v, 16'h0000);

        // R5 latched until port read
        @(negedge clk); pin_in[0] = 1'b0;
        settle(4);
        @(negedge clk); pin_in[0] = 1'b1;
        settle(4);
        @(negedge clk); pin_in[0] = 1'b0;
        settle(4);
        rd(3'd3, v); check("R5 held after pin return", v, 16'h0001);
        rd(3'd0, v); check("R5 port data", v, 16'h0000);
        rd(3'd3, v); check("R5 cleared by port read", v, 16'h0000);
        check("R5 irq_n released", {15'd0, irq_n}, 16'h0001);

        // R3 masked line records status without interrupt
        wr(3'd2, 16'h0000);
        @(negedge clk); pin_in[0] = 1'b1;
        settle(4);
        rd(3'd3, v); check("R3 status while masked", v, 16'h0001);
        check("R3 irq_n masked", {15'd0, irq_n}, 16'h0001);
        wr(3'd2, 16'h0001);
        check("R3 irq_n unmasked", {15'd0, irq_n}, 16'h0000);
        wr(3'd4, 16'hFFFF);

        // R9 event on line 1 in the same cycle as its clear write
        wr(3'd6, 16'h0003); wr(3'd5, 16'h0003);
        settle(2);
        @(negedge clk); pin_in[1] = 1'b1;
        @(negedge clk);
        @(negedge clk); addr = 3'd4; wdata = 16'h0002; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
        rd(3'd3, v); check("R9 event beats clear", v & 16'h0002, 16'h0002);
        wr(3'd4, 16'h0002);
        rd(3'd3, v); check("R7 line1 cleared", v & 16'h0002, 16'h0000);

        // R10 level line 2, latched: port read reloads reference
        wr(3'd5, 16'h0007);
        @(negedge clk); pin_in[2] = 1'b1;
        settle(4);
        rd(3'd3, v); check("R10 level pending", v & 16'h0004, 16'h0004);
        rd(3'd0, v); check("R10 port data", v & 16'h0004, 16'h0004);
        settle(3);
        rd(3'd3, v); check("R10 no re-event", v & 16'h0004, 16'h0000);

        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                mismatched++;
                compared++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule